// File: doc/BRIEF.md
# Bridge System Error Reporting Unit

This unit sits in a two-port bus bridge and decides when the bridge drives its primary-side, active-low system error output. It watches a set of one-cycle event strobes: target abort and master abort on posted writes, a data parity error that the target reported during a posted write, and target-retry responses on posted and delayed writes. It also watches the secondary-side system error input. It combines these with four configuration enable bits that come from the command and bridge-control registers.

Four retry counters, one for each write type and direction, count the delivery attempts of the write at the head of each path. When a counter reaches its limit, the unit treats the write data as discarded and raises a system error. Two sticky status flags record that the bridge signalled a system error and that it received one from the secondary side. Each flag is cleared by a write-one-to-clear strobe.

Every qualifying event drives the output low for exactly one clock, in the cycle after the edge that samples the event. Events that arrive in the same cycle produce a single low cycle.

Top module: `bridge_serr_unit`

## Requirements
- R1: While `rst` is high and after its release, `pri_serr_n` is 1, both status flags are 0 and all retry counters are 0.
- R2: When `cmd_serr_en` is 0 in a cycle, `pri_serr_n` is 1 in the following cycle, whatever events occur.
- R3: A qualifying event sampled at a clock edge drives `pri_serr_n` to 0 for exactly the next cycle. Several events in one cycle give one low cycle. With no event, the output stays 1.
- R4: `sts_sig_serr` becomes 1 whenever `pri_serr_n` is driven low. It stays 1 until `clr_sig` is pulsed, and a set in the same cycle as the clear wins.
- R5: A high-to-low transition of `sec_serr_n` while `bctl_serr_fwd` is 1 is a qualifying event. The same transition sets `sts_rcv_serr` even when `cmd_serr_en` is 0, and `clr_rcv` clears that flag. Holding `sec_serr_n` low gives only one event. With `bctl_serr_fwd` at 0 the transition has no effect.
- R6: `pw_tabort` and `pw_mabort` are qualifying events.
- R7: `pw_perr` is a qualifying event only when all of the following hold: `cmd_perr_resp` is 1, `bctl_perr_resp` is 1, `pw_perr_self` is 0, and the bus that observed the error is the target side of the write. The target side is the secondary bus (`pw_perr_sec`=1) for downstream writes (`pw_perr_up`=0) and the primary bus (`pw_perr_sec`=0) for upstream writes (`pw_perr_up`=1).
- R8: A parity error that fails any condition of R7 has no effect on `pri_serr_n`.
- R9: Each retry counter is 2^RETRY_W wide in range. The 2^RETRY_W-th consecutive retry strobe on a path is a qualifying discard event, and the counter then restarts from 0. The path is chosen by the `*_up` tag, where 0 means downstream.
- R10: A done strobe on a path clears that path's counter, and it wins over a retry in the same cycle. The four paths (posted/delayed × down/up) count independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_serr_en | input | 1 | System error enable (command register) |
| cmd_perr_resp | input | 1 | Parity error response (command register) |
| bctl_perr_resp | input | 1 | Secondary parity error response (bridge control) |
| bctl_serr_fwd | input | 1 | Secondary system error forward enable |
| sec_serr_n | input | 1 | Secondary system error input, active low |
| pw_tabort | input | 1 | Posted-write target abort strobe |
| pw_mabort | input | 1 | Posted-write master abort strobe |
| pw_perr | input | 1 | Target-reported parity error on a posted write |
| pw_perr_up | input | 1 | Direction of the parity error write (1 = upstream) |
| pw_perr_sec | input | 1 | Bus that observed the error (1 = secondary) |
| pw_perr_self | input | 1 | Bridge itself detected the error as target |
| pw_retry | input | 1 | Posted-write target retry strobe |
| pw_retry_up | input | 1 | Direction of the posted retry |
| pw_done | input | 1 | Posted write completed |
| pw_done_up | input | 1 | Direction of the posted completion |
| dw_retry | input | 1 | Delayed-write target retry strobe |
| dw_retry_up | input | 1 | Direction of the delayed retry |
| dw_done | input | 1 | Delayed write completed |
| dw_done_up | input | 1 | Direction of the delayed completion |
| clr_sig | input | 1 | Write-one-to-clear for signaled flag |
| clr_rcv | input | 1 | Write-one-to-clear for received flag |
| pri_serr_n | output | 1 | Primary system error output, active low |
| sts_sig_serr | output | 1 | Sticky signaled-system-error flag |
| sts_rcv_serr | output | 1 | Sticky received-system-error flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a flag being set and its own clear strobe. The second pair is several error sources raising a reason together: an abort, a qualifying parity error and a counter discard. The bench provokes the first by pulsing `clr_sig` in the same cycle as a target abort, and judges it by `sts_sig_serr` staying 1. It provokes the second by firing several strobes in one vector, and judges it by exactly one low cycle on `pri_serr_n` followed by a high cycle. A done strobe coinciding with a retry is also driven, and the bench checks that the counter restarts rather than advancing.

// File: rtl/bridge_serr_unit.sv
module bridge_serr_unit #(
  parameter int RETRY_W = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_serr_en,
  input  logic cmd_perr_resp,
  input  logic bctl_perr_resp,
  input  logic bctl_serr_fwd,
  input  logic sec_serr_n,
  input  logic pw_tabort,
  input  logic pw_mabort,
  input  logic pw_perr,
  input  logic pw_perr_up,
  input  logic pw_perr_sec,
  input  logic pw_perr_self,
  input  logic pw_retry,
  input  logic pw_retry_up,
  input  logic pw_done,
  input  logic pw_done_up,
  input  logic dw_retry,
  input  logic dw_retry_up,
  input  logic dw_done,
  input  logic dw_done_up,
  input  logic clr_sig,
  input  logic clr_rcv,
  output logic pri_serr_n,
  output logic sts_sig_serr,
  output logic sts_rcv_serr
);

  localparam int NPATH = 4;

  logic [NPATH-1:0] rty, dn, dsc;
  logic [RETRY_W-1:0] cnt [NPATH];
  logic sec_q;

  // path order: posted down, posted up, delayed down, delayed up
  assign rty = {dw_retry & dw_retry_up, dw_retry & ~dw_retry_up,
                pw_retry & pw_retry_up, pw_retry & ~pw_retry_up};
  assign dn  = {dw_done & dw_done_up, dw_done & ~dw_done_up,
                pw_done & pw_done_up, pw_done & ~pw_done_up};

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    assign dsc[g] = rty[g] & ~dn[g] & (&cnt[g]);
    always_ff @(posedge clk) begin
      if (rst || dn[g])
        cnt[g] <= '0;
      else if (rty[g])
        cnt[g] <= cnt[g] + 1'b1;
    end
  end

  wire sec_evt  = sec_q & ~sec_serr_n;
  wire fwd_evt  = sec_evt & bctl_serr_fwd;
  wire perr_ok  = pw_perr & ~pw_perr_self & cmd_perr_resp & bctl_perr_resp &
                  (pw_perr_up ^ pw_perr_sec);
  wire reason   = fwd_evt | pw_tabort | pw_mabort | perr_ok | (|dsc);
  wire fire     = cmd_serr_en & reason;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q        <= 1'b1;
      pri_serr_n   <= 1'b1;
      sts_sig_serr <= 1'b0;
      sts_rcv_serr <= 1'b0;
    end else begin
      sec_q        <= sec_serr_n;
      pri_serr_n   <= ~fire;
      sts_sig_serr <= fire | (sts_sig_serr & ~clr_sig);
      sts_rcv_serr <= fwd_evt | (sts_rcv_serr & ~clr_rcv);
    end
  end

endmodule

// File: rtl/bridge_serr_unit_chk.sv
module bridge_serr_unit_chk (
  input logic clk,
  input logic rst,
  input logic cmd_serr_en,
  input logic sec_serr_n,
  input logic pw_tabort,
  input logic pw_mabort,
  input logic pw_perr,
  input logic pw_retry,
  input logic dw_retry,
  input logic clr_sig,
  input logic clr_rcv,
  input logic pri_serr_n,
  input logic sts_sig_serr,
  input logic sts_rcv_serr
);

  // R2
  gated_by_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_serr_en |=> pri_serr_n);

  // R3
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!pw_tabort && !pw_mabort && !pw_perr && !pw_retry && !dw_retry && sec_serr_n)
    |=> pri_serr_n);

  // R4
  sig_follows_out_chk: assert property (@(posedge clk) disable iff (rst)
    !pri_serr_n |-> sts_sig_serr);

  // R4
  sig_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sts_sig_serr) |-> $past(clr_sig));

  // R5
  rcv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sts_rcv_serr) |-> $past(clr_rcv));

  // R6
  abort_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_serr_en && (pw_tabort || pw_mabort)) |=> !pri_serr_n);

endmodule

bind bridge_serr_unit bridge_serr_unit_chk u_chk (.*);

// File: tb/test_bridge_serr_unit.sv
module test_bridge_serr_unit;

  logic clk = 1'b0;
  logic rst;
  logic cmd_serr_en, cmd_perr_resp, bctl_perr_resp, bctl_serr_fwd, sec_serr_n;
  logic pw_tabort, pw_mabort, pw_perr, pw_perr_up, pw_perr_sec, pw_perr_self;
  logic pw_retry, pw_retry_up, pw_done, pw_done_up;
  logic dw_retry, dw_retry_up, dw_done, dw_done_up;
  logic clr_sig, clr_rcv;
  logic pri_serr_n, sts_sig_serr, sts_rcv_serr;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bridge_serr_unit #(.RETRY_W(3)) i_bridge_serr_unit (.*);

  localparam int LIM = 8;

  // {en, pr, bpr, tab, mab, perr, up, sec, self, exp_low}
  localparam logic [9:0] VEC [12] = '{
    10'b1_00_10_0000_1,
    10'b1_00_01_0100_1,
    10'b0_00_10_0000_0,
    10'b1_11_00_1010_1,
    10'b1_11_00_1000_0,
    10'b1_11_00_1100_1,
    10'b1_11_00_1110_0,
    10'b1_10_00_1010_0,
    10'b1_01_00_1010_0,
    10'b1_11_00_1011_0,
    10'b0_11_00_1010_0,
    10'b1_11_11_1010_1
  };

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle_strobes();
    pw_tabort = 0; pw_mabort = 0; pw_perr = 0; pw_perr_self = 0;
    pw_retry = 0; pw_done = 0; dw_retry = 0; dw_done = 0;
    clr_sig = 0; clr_rcv = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_strobes();
  endtask

  task automatic clear_all();
    clr_sig = 1; clr_rcv = 1;
    @(negedge clk);
    idle_strobes();
  endtask

  task automatic retries(input bit dly, input bit up, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      if (dly) begin dw_retry = 1; dw_retry_up = up; end
      else begin pw_retry = 1; pw_retry_up = up; end
      @(negedge clk);
      idle_strobes();
      chk(req, pri_serr_n, 1'b1);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; sec_serr_n = 1;
    cmd_serr_en = 1; cmd_perr_resp = 0; bctl_perr_resp = 0; bctl_serr_fwd = 0;
    pw_perr_up = 0; pw_perr_sec = 0; pw_retry_up = 0; pw_done_up = 0;
    dw_retry_up = 0; dw_done_up = 0;
    idle_strobes();
    pw_tabort = 1;
    repeat (3) @(negedge clk);
    chk("R1 out", pri_serr_n, 1'b1);
    chk("R1 sig", sts_sig_serr, 1'b0);
    chk("R1 rcv", sts_rcv_serr, 1'b0);
    rst = 0;
    idle_strobes();
    tick();
    chk("R1 after release", pri_serr_n, 1'b1);

    for (int v = 0; v < 12; v++) begin
      {cmd_serr_en, cmd_perr_resp, bctl_perr_resp, pw_tabort, pw_mabort,
       pw_perr, pw_perr_up, pw_perr_sec, pw_perr_self} = VEC[v][9:1];
      @(negedge clk);
      idle_strobes();
      chk("R2 R6 R7 R8 vector out", pri_serr_n, ~VEC[v][0]);
      chk("R4 vector sig", sts_sig_serr, VEC[v][0]);
      @(negedge clk);
      chk("R3 single pulse", pri_serr_n, 1'b1);
      clear_all();
    end

    cmd_serr_en = 1; cmd_perr_resp = 0; bctl_perr_resp = 0;
    pw_tabort = 1; clr_sig = 1;
    tick();
    chk("R4 set wins clear", sts_sig_serr, 1'b1);
    tick();
    chk("R4 sticky", sts_sig_serr, 1'b1);
    clr_sig = 1;
    tick();
    chk("R4 w1c", sts_sig_serr, 1'b0);

    bctl_serr_fwd = 1; sec_serr_n = 0;
    tick();
    chk("R5 fwd out", pri_serr_n, 1'b0);
    chk("R5 rcv set", sts_rcv_serr, 1'b1);
    tick();
    chk("R5 held low one pulse", pri_serr_n, 1'b1);
    sec_serr_n = 1;
    tick();
    clear_all();
    chk("R5 rcv w1c", sts_rcv_serr, 1'b0);
    bctl_serr_fwd = 0; sec_serr_n = 0;
    tick();
    chk("R5 no fwd out", pri_serr_n, 1'b1);
    chk("R5 no fwd rcv", sts_rcv_serr, 1'b0);
    sec_serr_n = 1;
    tick();
    bctl_serr_fwd = 1; cmd_serr_en = 0; sec_serr_n = 0;
    tick();
    chk("R5 R2 disabled out", pri_serr_n, 1'b1);
    chk("R5 rcv without enable", sts_rcv_serr, 1'b1);
    chk("R2 sig without enable", sts_sig_serr, 1'b0);
    sec_serr_n = 1; cmd_serr_en = 1;
    tick();
    clear_all();

    retries(0, 0, LIM - 1, "R9 posted down below limit");
    pw_retry = 1; pw_retry_up = 0;
    tick();
    chk("R9 posted down discard", pri_serr_n, 1'b0);
    retries(0, 0, LIM - 1, "R9 restart after discard");
    pw_done = 1; pw_done_up = 0;
    tick();

    retries(1, 0, 5, "R10 delayed down partial");
    dw_done = 1; dw_done_up = 0;
    tick();
    retries(1, 0, LIM - 1, "R10 done clears");
    dw_retry = 1; dw_retry_up = 0;
    tick();
    chk("R9 delayed down discard", pri_serr_n, 1'b0);

    retries(0, 1, LIM - 1, "R10 posted up partial");
    retries(0, 0, 1, "R10 other path independent");
    retries(1, 1, 1, "R10 delayed up independent");
    pw_retry = 1; pw_retry_up = 1;
    tick();
    chk("R9 posted up discard", pri_serr_n, 1'b0);

    retries(1, 1, LIM - 2, "R10 delayed up partial");
    dw_retry = 1; dw_retry_up = 1; dw_done = 1; dw_done_up = 1;
    tick();
    chk("R10 done beats retry", pri_serr_n, 1'b1);
    retries(1, 1, LIM - 1, "R10 restart after done");
    dw_retry = 1; dw_retry_up = 1; pw_tabort = 1;
    tick();
    chk("R3 R9 coincident one pulse", pri_serr_n, 1'b0);
    tick();
    chk("R3 coincident then high", pri_serr_n, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule